// File: doc/BRIEF.md
# USB Endpoint Handshake Selector with Halt and Protocol Stall

This block chooses the handshake that a USB device function returns for each token it receives. For every token it answers ACK, NAK or STALL, or it stays silent. It stores one halt bit for each non-control endpoint and one protocol-stall bit for control endpoint 0. The packet transmitter takes the 2-bit handshake code and turns it into the matching PID.

Two kinds of stall are kept apart. A functional stall is an endpoint's halt feature. Only a set-feature request sets it, and only a clear-feature request removes it. Clearing it also sends a one-cycle pulse that resets that endpoint's data toggle to DATA0. A protocol stall is raised by the control-transfer tracker when it rejects a request during the SETUP or DATA stage. It ends by itself when the next SETUP token is accepted on endpoint 0. A handshake that the host sends toward the device, including a STALL, is never answered and has no effect on any state.

Top module: `usb_stall_hs`

## Requirements
- R1: After `rst_n` goes low, and until the first token after its synchronised release, `hs_code_o` is NONE (0) and `toggle_clr_o` is all zero. The reset clears every halt bit and the protocol-stall bit.
- R2: An OUT (`tok_type_i`=0) or IN (1) token to a halted endpoint from 1 to NUM_EP-1 is answered STALL (3), whatever the state of `ep_ready_i`.
- R3: `feat_set_halt_i` sets the halt bit of the endpoint named by `feat_ep_i`. A set aimed at endpoint 0, or at an endpoint number of NUM_EP or more, is ignored.
- R4: `feat_clr_halt_i` clears the named endpoint's halt bit and pulses that endpoint's bit of `toggle_clr_o` for one cycle. If set and clear arrive together for the same endpoint, the clear wins.
- R5: The protocol-stall bit is set when `ctl_reject_i` is high while `ctl_stage_i` is SETUP (1) or DATA (2). A reject during IDLE (0) or STATUS (3) is ignored.
- R6: While the protocol-stall bit is set, OUT and IN tokens to endpoint 0 are answered STALL. Other endpoints are not affected.
- R7: A SETUP token (`tok_type_i`=2) to endpoint 0 is always answered ACK and clears the protocol-stall bit. A reject in the same cycle sets the bit again.
- R8: An OUT or IN token to an endpoint that is not stalled is answered NAK (2) when that endpoint's `ep_ready_i` bit is 0, and ACK (1) when it is 1.
- R9: A host-handshake token (`tok_type_i`=3) gets the answer NONE and changes no state.
- R10: `bus_reset_i` clears every halt bit and the protocol-stall bit.
- R11: A token to an endpoint number of NUM_EP or more, or a SETUP token to a non-zero endpoint, gets the answer NONE.
- R12: The handshake code and the toggle-clear pulse appear exactly one clock after their stimulus. In every other cycle the code is NONE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_reset_i | input | 1 | USB bus reset seen on the line |
| tok_valid_i | input | 1 | A decoded token is presented this cycle |
| tok_type_i | input | 2 | 0 OUT, 1 IN, 2 SETUP, 3 handshake sent by the host |
| tok_ep_i | input | EP_W | Endpoint number of the token |
| ctl_stage_i | input | 2 | Control stage: 0 IDLE, 1 SETUP, 2 DATA, 3 STATUS |
| ctl_reject_i | input | 1 | Control tracker rejects the current request |
| ep_ready_i | input | NUM_EP | Per-endpoint buffer ready |
| feat_set_halt_i | input | 1 | Set-feature halt request |
| feat_clr_halt_i | input | 1 | Clear-feature halt request |
| feat_ep_i | input | EP_W | Target endpoint of the feature request |
| hs_code_o | output | 2 | 0 NONE, 1 ACK, 2 NAK, 3 STALL |
| toggle_clr_o | output | NUM_EP | One-cycle pulse: reset the data toggle of that endpoint |

## Verification
Every result of this block comes from exactly one register stage. The handshake for a token, the toggle-clear pulse for a clear-feature request, and a change to a halt or protocol-stall bit all take effect on the first rising edge after the stimulus. The bench drives each vector on a falling edge and compares both outputs on the next falling edge, which is one rising edge later. A stall-state change made by one vector is then seen by the token of the following vector. After a reset the bench waits out the two-stage reset synchroniser before it drives any token.

// File: rtl/usb_hs_pkg.sv
package usb_hs_pkg;

  typedef enum logic [1:0] {
    TOK_OUT     = 2'd0,
    TOK_IN      = 2'd1,
    TOK_SETUP   = 2'd2,
    TOK_HOST_HS = 2'd3
  } tok_e;

  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_ACK   = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hs_e;

  typedef enum logic [1:0] {
    CS_IDLE   = 2'd0,
    CS_SETUP  = 2'd1,
    CS_DATA   = 2'd2,
    CS_STATUS = 2'd3
  } cstage_e;

endpackage

// File: rtl/usb_halt_bank.sv
module usb_halt_bank #(
  parameter int NUM_EP = 4,
  parameter int EP_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset_i,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [EP_W-1:0]   ep_i,
  output logic [NUM_EP-1:0] halt_o,
  output logic [NUM_EP-1:0] tog_clr_o
);

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    logic sel;
    logic tog_d, tog_q;

    assign sel   = (ep_i == EP_W'(e));
    assign tog_d = clr_i && sel && !bus_reset_i;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tog_q <= 1'b0;
      else        tog_q <= tog_d;
    end
    assign tog_clr_o[e] = tog_q;

    if (e == 0) begin : g_ctrl
      // the control endpoint has no functional halt
      assign halt_o[e] = 1'b0;
    end else begin : g_data
      logic halt_d, halt_q, halt_en;

      assign halt_en = bus_reset_i || (sel && (set_i || clr_i));

      always_comb begin
        halt_d = halt_q;
        if (bus_reset_i)      halt_d = 1'b0;
        else if (sel && clr_i) halt_d = 1'b0;
        else if (sel && set_i) halt_d = 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       halt_q <= 1'b0;
        else if (halt_en) halt_q <= halt_d;
      end
      assign halt_o[e] = halt_q;
    end
  end

endmodule

// File: rtl/usb_proto_stall.sv
module usb_proto_stall
  import usb_hs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    bus_reset_i,
  input  logic    setup_ep0_i,
  input  logic    reject_i,
  input  cstage_e stage_i,
  output logic    pstall_o
);

  logic arm, pst_d, pst_q, pst_en;

  assign arm    = reject_i && (stage_i == CS_SETUP || stage_i == CS_DATA);
  assign pst_en = bus_reset_i || arm || setup_ep0_i;

  always_comb begin
    pst_d = pst_q;
    if (bus_reset_i)      pst_d = 1'b0;
    else if (arm)         pst_d = 1'b1;
    else if (setup_ep0_i) pst_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pst_q <= 1'b0;
    else if (pst_en) pst_q <= pst_d;
  end

  assign pstall_o = pst_q;

endmodule

// File: rtl/usb_hs_select.sv
module usb_hs_select
  import usb_hs_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int EP_W   = 4
) (
  input  logic              tok_valid_i,
  input  tok_e              tok_type_i,
  input  logic [EP_W-1:0]   tok_ep_i,
  input  logic [NUM_EP-1:0] halt_i,
  input  logic              pstall_i,
  input  logic [NUM_EP-1:0] ready_i,
  output hs_e               hs_o
);

  localparam int IDX_W = $clog2(NUM_EP);

  logic             in_rng, is_ep0, stalled;
  logic [IDX_W-1:0] idx;

  assign in_rng  = (tok_ep_i <= EP_W'(NUM_EP - 1));
  assign is_ep0  = (tok_ep_i == '0);
  assign idx     = tok_ep_i[IDX_W-1:0];
  assign stalled = is_ep0 ? pstall_i : halt_i[idx];

  always_comb begin
    hs_o = HS_NONE;
    if (tok_valid_i) begin
      unique case (tok_type_i)
        TOK_HOST_HS: hs_o = HS_NONE;
        TOK_SETUP:   hs_o = is_ep0 ? HS_ACK : HS_NONE;
        default: begin
          if (!in_rng)           hs_o = HS_NONE;
          else if (stalled)      hs_o = HS_STALL;
          else if (!ready_i[idx]) hs_o = HS_NAK;
          else                   hs_o = HS_ACK;
        end
      endcase
    end
  end

endmodule

// File: rtl/usb_stall_hs.sv
module usb_stall_hs
  import usb_hs_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int EP_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset_i,
  input  logic              tok_valid_i,
  input  logic [1:0]        tok_type_i,
  input  logic [EP_W-1:0]   tok_ep_i,
  input  logic [1:0]        ctl_stage_i,
  input  logic              ctl_reject_i,
  input  logic [NUM_EP-1:0] ep_ready_i,
  input  logic              feat_set_halt_i,
  input  logic              feat_clr_halt_i,
  input  logic [EP_W-1:0]   feat_ep_i,
  output logic [1:0]        hs_code_o,
  output logic [NUM_EP-1:0] toggle_clr_o
);

  logic rs_meta, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rs_meta    <= 1'b1;
      rst_sync_n <= rs_meta;
    end
  end

  tok_e              tok_type;
  logic [NUM_EP-1:0] halt_vec;
  logic              pstall;
  logic              setup_ep0;
  hs_e               hs_d, hs_q;

  assign tok_type  = tok_e'(tok_type_i);
  assign setup_ep0 = tok_valid_i && (tok_type == TOK_SETUP) && (tok_ep_i == '0);

  usb_halt_bank #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_halt (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .bus_reset_i (bus_reset_i),
    .set_i       (feat_set_halt_i),
    .clr_i       (feat_clr_halt_i),
    .ep_i        (feat_ep_i),
    .halt_o      (halt_vec),
    .tog_clr_o   (toggle_clr_o)
  );

  usb_proto_stall u_pstall (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .bus_reset_i (bus_reset_i),
    .setup_ep0_i (setup_ep0),
    .reject_i    (ctl_reject_i),
    .stage_i     (cstage_e'(ctl_stage_i)),
    .pstall_o    (pstall)
  );

  usb_hs_select #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_sel (
    .tok_valid_i (tok_valid_i),
    .tok_type_i  (tok_type),
    .tok_ep_i    (tok_ep_i),
    .halt_i      (halt_vec),
    .pstall_i    (pstall),
    .ready_i     (ep_ready_i),
    .hs_o        (hs_d)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) hs_q <= HS_NONE;
    else             hs_q <= hs_d;
  end

  assign hs_code_o = hs_q;

endmodule

// File: rtl/usb_stall_hs_chk.sv
module usb_stall_hs_chk #(
  parameter int NUM_EP = 4,
  parameter int EP_W   = 4
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              bus_reset_i,
  input logic              tok_valid_i,
  input logic [1:0]        tok_type_i,
  input logic [EP_W-1:0]   tok_ep_i,
  input logic              ctl_reject_i,
  input logic [NUM_EP-1:0] ep_ready_i,
  input logic              feat_clr_halt_i,
  input logic [EP_W-1:0]   feat_ep_i,
  input logic [NUM_EP-1:0] halt_vec,
  input logic              pstall,
  input logic [1:0]        hs_code_o,
  input logic [NUM_EP-1:0] toggle_clr_o
);

  localparam int IDX_W = $clog2(NUM_EP);

  logic             tok_rng, feat_rng, data_tok, halt_hit, rdy_hit;
  logic [IDX_W-1:0] tidx, fidx;

  assign tidx     = tok_ep_i[IDX_W-1:0];
  assign fidx     = feat_ep_i[IDX_W-1:0];
  assign tok_rng  = (tok_ep_i <= EP_W'(NUM_EP - 1));
  assign feat_rng = (feat_ep_i <= EP_W'(NUM_EP - 1));
  assign data_tok = tok_valid_i && (tok_type_i == 2'd0 || tok_type_i == 2'd1);
  assign halt_hit = tok_rng && halt_vec[tidx];
  assign rdy_hit  = tok_rng && ep_ready_i[tidx];

  // R2
  p_halt_stall_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    data_tok && tok_ep_i != '0 && halt_hit |=> hs_code_o == 2'd3);

  // R4
  p_toggle_pulse_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    feat_clr_halt_i && feat_rng && !bus_reset_i |=> toggle_clr_o[$past(fidx)]);

  p_toggle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !feat_clr_halt_i |=> toggle_clr_o == '0);

  // R6
  p_pstall_stall_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    data_tok && tok_ep_i == '0 && pstall |=> hs_code_o == 2'd3);

  // R7
  p_setup_ack_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tok_valid_i && tok_type_i == 2'd2 && tok_ep_i == '0 |=> hs_code_o == 2'd1);

  p_setup_clears_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tok_valid_i && tok_type_i == 2'd2 && tok_ep_i == '0 && !ctl_reject_i |=> !pstall);

  // R8
  p_nak_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    data_tok && tok_rng && tok_ep_i != '0 && !halt_hit && !rdy_hit |=> hs_code_o == 2'd2);

  // R9
  p_host_hs_silent_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tok_valid_i && tok_type_i == 2'd3 |=> hs_code_o == 2'd0);

  // R10
  p_bus_reset_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_reset_i |=> halt_vec == '0 && !pstall);

  // R12
  p_idle_silent_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !tok_valid_i |=> hs_code_o == 2'd0);

endmodule

bind usb_stall_hs usb_stall_hs_chk #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_chk (
  .clk             (clk),
  .rst_sync_n      (rst_sync_n),
  .bus_reset_i     (bus_reset_i),
  .tok_valid_i     (tok_valid_i),
  .tok_type_i      (tok_type_i),
  .tok_ep_i        (tok_ep_i),
  .ctl_reject_i    (ctl_reject_i),
  .ep_ready_i      (ep_ready_i),
  .feat_clr_halt_i (feat_clr_halt_i),
  .feat_ep_i       (feat_ep_i),
  .halt_vec        (halt_vec),
  .pstall          (pstall),
  .hs_code_o       (hs_code_o),
  .toggle_clr_o    (toggle_clr_o)
);

// File: tb/tb_usb_stall_hs.sv
module tb_usb_stall_hs;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_EP     = 4;
  localparam int EP_W       = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_reset_i;
  logic              tok_valid_i;
  logic [1:0]        tok_type_i;
  logic [EP_W-1:0]   tok_ep_i;
  logic [1:0]        ctl_stage_i;
  logic              ctl_reject_i;
  logic [NUM_EP-1:0] ep_ready_i;
  logic              feat_set_halt_i;
  logic              feat_clr_halt_i;
  logic [EP_W-1:0]   feat_ep_i;
  logic [1:0]        hs_code_o;
  logic [NUM_EP-1:0] toggle_clr_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  usb_stall_hs #(.NUM_EP(NUM_EP), .EP_W(EP_W)) dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_reset_i     (bus_reset_i),
    .tok_valid_i     (tok_valid_i),
    .tok_type_i      (tok_type_i),
    .tok_ep_i        (tok_ep_i),
    .ctl_stage_i     (ctl_stage_i),
    .ctl_reject_i    (ctl_reject_i),
    .ep_ready_i      (ep_ready_i),
    .feat_set_halt_i (feat_set_halt_i),
    .feat_clr_halt_i (feat_clr_halt_i),
    .feat_ep_i       (feat_ep_i),
    .hs_code_o       (hs_code_o),
    .toggle_clr_o    (toggle_clr_o)
  );

  // token: 0 OUT 1 IN 2 SETUP 3 host handshake; code: 0 NONE 1 ACK 2 NAK 3 STALL
  typedef struct packed {
    logic       tv;
    logic [1:0] tt;
    logic [3:0] tep;
    logic       fs;
    logic       fc;
    logic [3:0] fep;
    logic       rj;
    logic [1:0] stg;
    logic [3:0] rdy;
    logic       br;
    logic [1:0] exp_hs;
    logic [3:0] exp_tg;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd0, 4'd1, 1'b0, 1'b0, 4'd0, 1'b0, 2'd0, 4'hF, 1'b0, 2'd1, 4'h0, 8'd8},  // R8 ready ACK
    '{1'b1, 2'd1, 4'd2, 1'b0, 1'b0, 4'd0, 1'b0, 2'd0, 4'hB, 1'b0, 2'd2, 4'h0, 8'd8},  // R8 not ready NAK
    '{1'b0, 2'd0, 4'd0, 1'b1, 1'b0, 4'd1, 1'b0, 2'd0, 4'hF, 1'b0, 2'd0, 4'h0, 8'd3},  // R3 halt ep1
    '{1'b1, 2'd1, 4'd1, 1'b0, 1'b0, 4'd0, 1'b0, 2'd0, 4'hF, 1'b0, 2'd3, 4'h0, 8'd2},  // R2
    '{1'b1, 2'd0, 4'd1, 1'b0, 1'b0, 4'd0, 1'b0, 2'd0, 4'h0, 1'b0, 2'd3, 4'h0, 8'd2},  // R2 over NAK
    '{1'b0, 2'd0, 4'd0, 1'b1, 1'b0, 4'd0, 1'b0, 2'd0, 4'hF, 1'b0, 2'd0, 4'h0, 8'd3},  // R3 set ep0
    '{1'b1, 2'd1, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 2'd0, 4'hF, 1'b0, 2'd1, 4'h0, 8'd3},  // R3 ep0 unaffected
    '{1'b1, 2'd2, 4'd1, 1'b0, 1'b0, 4'd0, 1'b0, 2'd0, 4'hF, 1'b0, 2'd0, 4'h0, 8'd11}, // R11 setup ep1
    '{1'b1, 2'd0, 4'd9, 1'b0, 1'b0, 4'd0, 1'b0, 2'd0, 4'hF, 1'b0, 2'd0, 4'h0, 8'd11}, // R11 ep9
    '{1'b1, 2'd0, 4'd2, 1'b1, 1'b0, 4'd9, 1'b0, 2'd0, 4'hF, 1'b0, 2'd1, 4'h0, 8'd3},  // R3 set ep9
    '{1'b1, 2'd3, 4'd1, 1'b0, 1'b0, 4'd0, 1'b0, 2'd0, 4'hF, 1'b0, 2'd0, 4'h0, 8'd9},  // R9 silent
    '{1'b1, 2'd1, 4'd1, 1'b0, 1'b0, 4'd0, 1'b0, 2'd0, 4'hF, 1'b0, 2'd3, 4'h0, 8'd9},  // R9 halt kept
    '{1'b0, 2'd0, 4'd0, 1'b0, 1'b1, 4'd1, 1'b0, 2'd0, 4'hF, 1'b0, 2'd0, 4'h2, 8'd4},  // R4 clear ep1
    '{1'b1, 2'd1, 4'd1, 1'b0, 1'b0, 4'd0, 1'b0, 2'd0, 4'hF, 1'b0, 2'd1, 4'h0, 8'd4},  // R4
    '{1'b0, 2'd0, 4'd0, 1'b0, 1'b0, 4'd0, 1'b1, 2'd3, 4'hF, 1'b0, 2'd0, 4'h0, 8'd5},  // R5 STATUS reject
    '{1'b1, 2'd1, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 2'd0, 4'hF, 1'b0, 2'd1, 4'h0, 8'd5},  // R5 ignored
    '{1'b0, 2'd0, 4'd0, 1'b0, 1'b0, 4'd0, 1'b1, 2'd2, 4'hF, 1'b0, 2'd0, 4'h0, 8'd5},  // R5 DATA reject
    '{1'b1, 2'd1, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 2'd0, 4'hF, 1'b0, 2'd3, 4'h0, 8'd6},  // R6
    '{1'b1, 2'd0, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 2'd0, 4'h0, 1'b0, 2'd3, 4'h0, 8'd6},  // R6
    '{1'b1, 2'd1, 4'd3, 1'b0, 1'b0, 4'd0, 1'b0, 2'd0, 4'hF, 1'b0, 2'd1, 4'h0, 8'd6},  // R6 other ep
    '{1'b1, 2'd2, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 2'd1, 4'h0, 1'b0, 2'd1, 4'h0, 8'd7},  // R7 setup ACK
    '{1'b1, 2'd1, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 2'd1, 4'hF, 1'b0, 2'd1, 4'h0, 8'd7},  // R7 cleared
    '{1'b1, 2'd2, 4'd0, 1'b0, 1'b0, 4'd0, 1'b1, 2'd1, 4'hF, 1'b0, 2'd1, 4'h0, 8'd7},  // R7 reject wins
    '{1'b1, 2'd1, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 2'd0, 4'hF, 1'b0, 2'd3, 4'h0, 8'd7},  // R7
    '{1'b0, 2'd0, 4'd0, 1'b1, 1'b0, 4'd2, 1'b0, 2'd0, 4'hF, 1'b0, 2'd0, 4'h0, 8'd3},  // R3 halt ep2
    '{1'b1, 2'd0, 4'd2, 1'b1, 1'b0, 4'd3, 1'b0, 2'd0, 4'hF, 1'b0, 2'd3, 4'h0, 8'd2},  // R2 halt ep3
    '{1'b0, 2'd0, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 2'd0, 4'hF, 1'b1, 2'd0, 4'h0, 8'd10}, // R10 bus reset
    '{1'b1, 2'd1, 4'd2, 1'b0, 1'b0, 4'd0, 1'b0, 2'd0, 4'hF, 1'b0, 2'd1, 4'h0, 8'd10}, // R10
    '{1'b1, 2'd1, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 2'd0, 4'hF, 1'b0, 2'd1, 4'h0, 8'd10}, // R10
    '{1'b0, 2'd0, 4'd0, 1'b1, 1'b0, 4'd3, 1'b0, 2'd0, 4'hF, 1'b0, 2'd0, 4'h0, 8'd3},  // R3 halt ep3
    '{1'b0, 2'd0, 4'd0, 1'b1, 1'b1, 4'd3, 1'b0, 2'd0, 4'hF, 1'b0, 2'd0, 4'h8, 8'd4},  // R4 clear wins
    '{1'b1, 2'd1, 4'd3, 1'b0, 1'b0, 4'd0, 1'b0, 2'd0, 4'hF, 1'b0, 2'd1, 4'h0, 8'd4},  // R4
    '{1'b0, 2'd0, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 2'd0, 4'hF, 1'b0, 2'd0, 4'h0, 8'd12}  // R12 idle
  };

  task automatic idle_inputs();
    bus_reset_i     = 1'b0;
    tok_valid_i     = 1'b0;
    tok_type_i      = 2'd0;
    tok_ep_i        = '0;
    ctl_stage_i     = 2'd0;
    ctl_reject_i    = 1'b0;
    ep_ready_i      = '1;
    feat_set_halt_i = 1'b0;
    feat_clr_halt_i = 1'b0;
    feat_ep_i       = '0;
  endtask

  task automatic drive(input vec_t v);
    tok_valid_i     = v.tv;
    tok_type_i      = v.tt;
    tok_ep_i        = v.tep;
    feat_set_halt_i = v.fs;
    feat_clr_halt_i = v.fc;
    feat_ep_i       = v.fep;
    ctl_reject_i    = v.rj;
    ctl_stage_i     = v.stg;
    ep_ready_i      = v.rdy;
    bus_reset_i     = v.br;
  endtask

  task automatic check(input int req, input logic [1:0] exp_hs, input logic [3:0] exp_tg);
    checks++;
    if (hs_code_o !== exp_hs || toggle_clr_o !== exp_tg) begin
      failures++;
      $display("FAIL R%0d: hs=%0d tog=%h expected hs=%0d tog=%h",
               req, hs_code_o, toggle_clr_o, exp_hs, exp_tg);
    end
  endtask

  task automatic one_token(input logic [1:0] tt, input logic [3:0] ep);
    @(negedge clk);
    idle_inputs();
    tok_valid_i = 1'b1;
    tok_type_i  = tt;
    tok_ep_i    = ep;
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(1, 2'd0, 4'h0);  // R1 outputs quiet in reset
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(1, 2'd0, 4'h0);  // R1 outputs quiet after release

    // vector table: each result is due one rising edge after drive (R12)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (i > 0) check(int'(VEC[i-1].req), VEC[i-1].exp_hs, VEC[i-1].exp_tg);
      drive(VEC[i]);
    end
    @(negedge clk);
    check(int'(VEC[NV-1].req), VEC[NV-1].exp_hs, VEC[NV-1].exp_tg);
    idle_inputs();

    // R1: functional and protocol stall both cleared by reset
    @(negedge clk);
    feat_set_halt_i = 1'b1;
    feat_ep_i       = 4'd2;
    ctl_reject_i    = 1'b1;
    ctl_stage_i     = 2'd1;
    @(negedge clk);
    idle_inputs();
    one_token(2'd1, 4'd2);
    check(1, 2'd3, 4'h0);  // R1 precondition: ep2 halted
    rst_n = 1'b0;
    @(negedge clk);
    check(1, 2'd0, 4'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    one_token(2'd1, 4'd2);
    check(1, 2'd1, 4'h0);  // R1 halt cleared
    one_token(2'd1, 4'd0);
    check(1, 2'd1, 4'h0);  // R1 protocol stall cleared

    // R12: a response lasts exactly one cycle
    @(negedge clk);
    check(12, 2'd0, 4'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule